// File: doc/BRIEF.md
# Adaptive Sampling Rate Controller

This block sets the sampling rate of a slow sensor channel from the data that channel produces. Each finished 10-bit conversion is compared with the conversion before it. The absolute change is tested against thresholds that shrink as the rate rises, so the decision follows the signal's slope and not its raw step. The block then picks base, double or quadruple rate for the samples that follow. The three rate clocks come in as single-cycle tick strobes in the block's clock domain. The block forwards one of them as the sample trigger for the converter, and it reports the rate that is in force as a 2-bit clock-select code.

The select code changes only on a forwarded tick. A new choice therefore takes effect on the first tick of the newly chosen clock, and no shortened period reaches the converter. Every accepted conversion appears one cycle later on a record port, together with a 2-bit tag. The tag is the rate under which that conversion was launched, so the sample times can be rebuilt later from the stored stream.

Top module: `adaptive_rate_ctrl`

## Requirements
- R1: After reset, mode_o is 00 (base rate) and rec_valid_o is 0. Only tick_base_i is forwarded to sample_tick_o.
- R2: The rate codes are 00 for base, 01 for double and 10 for quadruple. Code 11 never appears on mode_o and is decoded as base.
- R3: The first conversion after reset only loads the previous-value register. It never changes the chosen rate, whatever its value.
- R4: The change is the absolute difference between the current and the previous conversion. Rises and falls count the same, and every accepted conversion becomes the new previous value.
- R5: The double-rate flag is raised when the change is strictly greater than 8 at base rate, 4 at double rate, or 2 at quadruple rate.
- R6: The quadruple-rate flag is raised when the change is strictly greater than 16 at base rate, 8 at double rate, or 4 at quadruple rate.
- R7: The next rate is quadruple if the quadruple flag is set. Otherwise it is double if the double flag is set, and base if neither flag is set. Any rate can be reached from any rate in one decision.
- R8: Once a rate has been chosen, only that rate's tick input is forwarded to sample_tick_o. mode_o takes the chosen code in the cycle after a forwarded tick, and at no other time.
- R9: One cycle after adc_valid_i, rec_valid_o is 1, rec_data_o holds the conversion and rec_tag_o holds the mode_o code in force when it arrived. rec_valid_o is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_base_i | input | 1 | One-cycle tick of the base-rate clock |
| tick_x2_i | input | 1 | One-cycle tick of the double-rate clock |
| tick_x4_i | input | 1 | One-cycle tick of the quadruple-rate clock |
| adc_valid_i | input | 1 | Conversion result valid strobe |
| adc_data_i | input | DATA_W | Conversion result |
| sample_tick_o | output | 1 | Forwarded sample trigger for the converter |
| mode_o | output | 2 | Clock-select code in force |
| rec_valid_o | output | 1 | Record strobe for storage |
| rec_data_o | output | DATA_W | Recorded conversion |
| rec_tag_o | output | 2 | Rate tag stored with the record |

## Verification
The assertions check the following on every cycle: mode_o holds a legal code and moves only after a forwarded tick, a forwarded tick always has a source tick behind it, and each record follows its strobe by one cycle with the right data and tag. The threshold arithmetic can only be shown by the bench's scenarios. These cover exact threshold values at each rate, falling steps, direct jumps between base and quadruple rate, suppressed ticks while a switch is pending, and priming after a reset in the middle of a run.

// File: rtl/asrc_pkg.sv
package asrc_pkg;
  localparam logic [1:0] MODE_BASE = 2'b00;
  localparam logic [1:0] MODE_X2   = 2'b01;
  localparam logic [1:0] MODE_X4   = 2'b10;
  localparam int unsigned N_RATES  = 3;

  // right-shift applied to thresholds; code 11 behaves as base
  function automatic logic [1:0] rate_shift(input logic [1:0] m);
    case (m)
      MODE_X2: rate_shift = 2'd1;
      MODE_X4: rate_shift = 2'd2;
      default: rate_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/arc_delta_judge.sv
module arc_delta_judge
  import asrc_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned X2_THR = 8
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] prev_i,
  input  logic [1:0]        mode_i,
  output logic              x2_flag_o,
  output logic              x4_flag_o
);
  localparam int unsigned THR_W = DATA_W + 1;

  logic [DATA_W-1:0]  diff;
  logic [N_RATES-1:0] x2_hit, x4_hit;

  always_comb diff = (cur_i >= prev_i) ? (cur_i - prev_i) : (prev_i - cur_i);

  // one comparator pair per rate, scaled by that rate
  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    localparam logic [THR_W-1:0] THR2 = THR_W'(X2_THR >> g);
    localparam logic [THR_W-1:0] THR4 = THR_W'((2 * X2_THR) >> g);
    assign x2_hit[g] = {1'b0, diff} > THR2;
    assign x4_hit[g] = {1'b0, diff} > THR4;
  end

  always_comb begin
    x2_flag_o = x2_hit[rate_shift(mode_i)];
    x4_flag_o = x4_hit[rate_shift(mode_i)];
  end
endmodule

// File: rtl/arc_mode_pick.sv
module arc_mode_pick
  import asrc_pkg::*;
(
  input  logic       x2_flag_i,
  input  logic       x4_flag_i,
  output logic [1:0] next_mode_o
);
  always_comb begin
    if (x4_flag_i)      next_mode_o = MODE_X4;
    else if (x2_flag_i) next_mode_o = MODE_X2;
    else                next_mode_o = MODE_BASE;
  end
endmodule

// File: rtl/arc_clk_select.sv
module arc_clk_select
  import asrc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pend_i,
  input  logic       tick_base_i,
  input  logic       tick_x2_i,
  input  logic       tick_x4_i,
  output logic       sample_tick_o,
  output logic [1:0] mode_o
);
  logic [1:0] mode_q;

  // forward only the pending rate's tick; the switch lands on that tick
  always_comb begin
    case (pend_i)
      MODE_X2: sample_tick_o = tick_x2_i;
      MODE_X4: sample_tick_o = tick_x4_i;
      default: sample_tick_o = tick_base_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mode_q <= MODE_BASE;
    else if (sample_tick_o) mode_q <= pend_i;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/adaptive_rate_ctrl.sv
module adaptive_rate_ctrl
  import asrc_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned X2_THR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_base_i,
  input  logic              tick_x2_i,
  input  logic              tick_x4_i,
  input  logic              adc_valid_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              sample_tick_o,
  output logic [1:0]        mode_o,
  output logic              rec_valid_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic [1:0]        rec_tag_o
);
  logic [DATA_W-1:0] prev_q;
  logic              primed_q;
  logic [1:0]        pend_q, next_mode;
  logic              x2_flag, x4_flag;

  arc_delta_judge #(.DATA_W(DATA_W), .X2_THR(X2_THR)) u_judge (
    .cur_i    (adc_data_i),
    .prev_i   (prev_q),
    .mode_i   (mode_o),
    .x2_flag_o(x2_flag),
    .x4_flag_o(x4_flag)
  );

  arc_mode_pick u_pick (
    .x2_flag_i  (x2_flag),
    .x4_flag_i  (x4_flag),
    .next_mode_o(next_mode)
  );

  arc_clk_select u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (pend_q),
    .tick_base_i  (tick_base_i),
    .tick_x2_i    (tick_x2_i),
    .tick_x4_i    (tick_x4_i),
    .sample_tick_o(sample_tick_o),
    .mode_o       (mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      pend_q   <= MODE_BASE;
    end else if (adc_valid_i) begin
      prev_q   <= adc_data_i;
      primed_q <= 1'b1;
      if (primed_q) pend_q <= next_mode;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_valid_o <= 1'b0;
      rec_data_o  <= '0;
      rec_tag_o   <= MODE_BASE;
    end else begin
      rec_valid_o <= adc_valid_i;
      if (adc_valid_i) begin
        rec_data_o <= adc_data_i;
        rec_tag_o  <= mode_o;
      end
    end
  end
endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_base_i,
  input logic              tick_x2_i,
  input logic              tick_x4_i,
  input logic              adc_valid_i,
  input logic [DATA_W-1:0] adc_data_i,
  input logic              sample_tick_o,
  input logic [1:0]        mode_o,
  input logic              rec_valid_o,
  input logic [DATA_W-1:0] rec_data_o,
  input logic [1:0]        rec_tag_o
);
  a_r2_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  a_r2_tag_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rec_tag_o != 2'b11);

  a_r8_mode_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(sample_tick_o));

  a_r8_tick_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o |-> (tick_base_i || tick_x2_i || tick_x4_i));

  a_r9_rec_follows_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_valid_i |=> rec_valid_o);

  a_r9_no_spurious_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_valid_i |=> !rec_valid_o);

  a_r9_rec_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_valid_i |=> rec_data_o == $past(adc_data_i));

  a_r9_rec_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_valid_i |=> rec_tag_o == $past(mode_o));
endmodule

bind adaptive_rate_ctrl arc_checker #(.DATA_W(DATA_W)) u_arc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_base_i  (tick_base_i),
  .tick_x2_i    (tick_x2_i),
  .tick_x4_i    (tick_x4_i),
  .adc_valid_i  (adc_valid_i),
  .adc_data_i   (adc_data_i),
  .sample_tick_o(sample_tick_o),
  .mode_o       (mode_o),
  .rec_valid_o  (rec_valid_o),
  .rec_data_o   (rec_data_o),
  .rec_tag_o    (rec_tag_o)
);

// File: tb/adaptive_rate_ctrl_bench.sv
module adaptive_rate_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_base = 1'b0, tb_x2 = 1'b0, tb_x4 = 1'b0;
  logic       adc_valid = 1'b0;
  logic [9:0] adc_data = '0;
  logic       sample_tick;
  logic [1:0] mode;
  logic       rec_valid;
  logic [9:0] rec_data;
  logic [1:0] rec_tag;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int exp_mode = 0;
  int exp_pend = 0;
  bit primed   = 0;
  int prev     = 0;

  always #4 clk = ~clk;

  adaptive_rate_ctrl u_adaptive_rate_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .tick_base_i(tb_base), .tick_x2_i(tb_x2), .tick_x4_i(tb_x4),
    .adc_valid_i(adc_valid), .adc_data_i(adc_data),
    .sample_tick_o(sample_tick), .mode_o(mode),
    .rec_valid_o(rec_valid), .rec_data_o(rec_data), .rec_tag_o(rec_tag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; adc_valid = 1'b0; tb_base = 0; tb_x2 = 0; tb_x4 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_mode = 0; exp_pend = 0; primed = 0; prev = 0;
  endtask

  // push one conversion and check its record
  task automatic do_sample(input int v, input string req);
    int s, d;
    @(negedge clk);
    adc_valid = 1'b1; adc_data = 10'(v);
    @(negedge clk);
    adc_valid = 1'b0;
    check({req, " R9 rec_valid"}, int'(rec_valid), 1);
    check({req, " R9 rec_data"}, int'(rec_data), v);
    check({req, " R9 rec_tag"}, int'(rec_tag), exp_mode);
    if (primed) begin
      s = (exp_mode == 1) ? 1 : (exp_mode == 2) ? 2 : 0;
      d = (v >= prev) ? v - prev : prev - v;
      if (d > (16 >> s))     exp_pend = 2;
      else if (d > (8 >> s)) exp_pend = 1;
      else                   exp_pend = 0;
    end
    primed = 1;
    prev = v;
    check({req, " R8 mode steady after sample"}, int'(mode), exp_mode);
    @(negedge clk);
    check({req, " R9 single record"}, int'(rec_valid), 0);
  endtask

  // drive a set of ticks, check forwarding and resulting mode
  task automatic do_tick(input bit b, input bit x2, input bit x4, input string req);
    bit exp_t;
    @(negedge clk);
    tb_base = b; tb_x2 = x2; tb_x4 = x4;
    #1;
    exp_t = (exp_pend == 1) ? x2 : (exp_pend == 2) ? x4 : b;
    check({req, " R8 forwarded tick"}, int'(sample_tick), int'(exp_t));
    @(negedge clk);
    tb_base = 0; tb_x2 = 0; tb_x4 = 0;
    if (exp_t) exp_mode = exp_pend;
    check({req, " R8 mode after tick"}, int'(mode), exp_mode);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 mode base", int'(mode), 0);
    check("R1 rec_valid low", int'(rec_valid), 0);
    do_tick(1, 0, 0, "R1 base tick");
    do_tick(0, 1, 1, "R1 fast ticks blocked");
  endtask

  task automatic t_prime();
    do_sample(500, "R3 first sample");
    do_tick(1, 1, 1, "R3 rate kept");
    check("R3 still base", int'(mode), 0);
  endtask

  task automatic t_base_thresholds();
    do_sample(508, "R5 diff 8 at base");
    do_tick(1, 1, 1, "R5 no switch");
    check("R5 base kept", int'(mode), 0);
    do_sample(517, "R5 diff 9 at base");
    do_tick(1, 0, 0, "R8 base tick while x2 pending");
    check("R8 mode held until x2 tick", int'(mode), 0);
    do_tick(0, 1, 0, "R2 x2 switch");
    check("R2 code 01", int'(mode), 1);
  endtask

  task automatic t_x2_thresholds();
    do_sample(521, "R5 diff 4 at x2");
    do_tick(1, 0, 0, "R7 drop to base");
    check("R7 base after small change", int'(mode), 0);
    do_sample(530, "R5 diff 9 at base");
    do_tick(0, 1, 0, "R5 up to x2");
    do_sample(535, "R5 diff 5 at x2");
    do_tick(0, 1, 0, "R5 hold x2");
    check("R5 x2 kept", int'(mode), 1);
    do_sample(543, "R6 diff 8 at x2");
    do_tick(0, 1, 0, "R6 not quad");
    check("R6 x2 kept at 8", int'(mode), 1);
    do_sample(534, "R4 falling diff 9 at x2");
    do_tick(0, 1, 1, "R6 quad switch");
    check("R2 code 10", int'(mode), 2);
  endtask

  task automatic t_x4_thresholds();
    do_sample(537, "R5 diff 3 at x4");
    do_tick(0, 1, 1, "R5 drop to x2");
    check("R5 x2 from x4", int'(mode), 1);
    do_sample(546, "R4 prev updated diff 9");
    do_tick(0, 0, 1, "R6 back to quad");
    do_sample(551, "R6 diff 5 at x4");
    do_tick(0, 0, 1, "R6 quad held");
    check("R6 x4 kept", int'(mode), 2);
    do_sample(553, "R5 diff 2 at x4");
    do_tick(1, 0, 0, "R7 base from x4");
    check("R7 direct x4 to base", int'(mode), 0);
    do_sample(570, "R6 diff 17 at base");
    do_tick(1, 1, 0, "R8 x4 pending blocks others");
    do_tick(0, 0, 1, "R7 base to x4 direct");
    check("R7 x4 reached", int'(mode), 2);
  endtask

  task automatic t_reset_reprime();
    do_reset();
    check("R1 mode base after rerun reset", int'(mode), 0);
    do_sample(1023, "R3 stale prev ignored");
    do_tick(1, 1, 1, "R3 base kept");
    check("R3 base after prime", int'(mode), 0);
    do_sample(0, "R4 full-scale fall");
    do_tick(0, 0, 1, "R6 full-scale quad");
    check("R6 x4 on large fall", int'(mode), 2);
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_prime();
    t_base_thresholds();
    t_x2_thresholds();
    t_x4_thresholds();
    t_reset_reprime();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule